// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block turns the fill levels of a UART's receive and transmit FIFOs into a live status word, and folds that word, together with line and channel event pulses, into a sticky interrupt status register. Software sees the live word, the sticky register, the interrupt mask and the two FIFO trigger levels through a small word-addressed register port. A single level interrupt is raised whenever a sticky bit that is enabled in the mask is set.

The FIFOs, the serializer and the baud generator sit outside. They supply their occupancy counts and single-cycle event pulses. The sticky register is cleared by writing ones. Any status condition that is still true sets its bit again on the next clock. The mask is changed only through a set register and a clear register. It can be read but not written directly.

Top module: `uart_irq_agg`

## Requirements
- R1: Live status word (register address 6): bit 0 is 1 while the receive count is at or above the receive trigger level. Bit 1 is 1 while the receive count is 0. Bit 2 is 1 while the receive count equals RX_DEPTH. These bits follow the inputs in the same cycle.
- R2: Live status bit 3 is 1 while the transmit count is 0. Bit 4 is 1 while the transmit count equals TX_DEPTH. Bit 13 is 1 while the transmit count is at or above the transmit trigger level. All other live bits read 0.
- R3: On each clock edge, live bits 4:0 are ORed into sticky bits 4:0 at the same positions, and live bit 13 is ORed into sticky bit 10. A condition that holds for a single cycle leaves its sticky bit set.
- R4: A single-cycle event pulse sets its sticky bit on the next clock edge. The positions are: receive overrun 5, framing 6, parity 7, receive timeout 8, modem status 9, transmit overrun 12. Sticky bit 11 stays 0.
- R5: The sticky register (address 3) is write-one-to-clear. A written 0 leaves a bit unchanged. A cleared bit whose status condition is still true reads 1 again after the write.
- R6: When a clearing write and a set source hit the same sticky bit in the same cycle, the bit ends up set.
- R7: Writing address 0 ORs the written bits 12:0 into the mask. Writing address 1 clears the mask bits written as 1. A write to the mask address 2 leaves the mask unchanged. The mask reads back at address 2.
- R8: irq_o is 1 exactly when some bit is set in both the mask and the sticky register.
- R9: While reset is held and right after it, the mask and the sticky register read 0, and both trigger levels read TRIG_RST (default 32).
- R10: The receive trigger level (address 4) and the transmit trigger level (address 5) are writable from the low CNT_W bits and read back. The new level takes effect in the live word on the next cycle. Reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address for read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| ev_rx_ovr_i | input | 1 | Receive overrun pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_timeout_i | input | 1 | Receive timeout pulse |
| ev_modem_i | input | 1 | Modem status change pulse |
| ev_tx_ovr_i | input | 1 | Transmit overrun pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume the FIFO counts never exceed their depths and that at most one register write arrives per cycle. They also treat an event pulse as a request to set a bit in the next cycle, regardless of how long it lasts. The stimulus keeps both counts between 0 and 64 and issues writes one at a time through a single task. It moves the counts to mid-range values (5 for both, with triggers at 32) before any test that needs a clean sticky register, so that no condition re-sets a bit unexpectedly. Events are pulsed for exactly one cycle, except where a pulse is deliberately placed in the same cycle as a clearing write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int LIVE_W   = 14;
  localparam int STICKY_W = 13;

  // live status positions
  localparam int LS_RX_TRIG  = 0;
  localparam int LS_RX_EMPTY = 1;
  localparam int LS_RX_FULL  = 2;
  localparam int LS_TX_EMPTY = 3;
  localparam int LS_TX_FULL  = 4;
  localparam int LS_TX_TRIG  = 13;

  // sticky positions
  localparam int IS_RX_OVR  = 5;
  localparam int IS_FRAME   = 6;
  localparam int IS_PARITY  = 7;
  localparam int IS_TIMEOUT = 8;
  localparam int IS_MODEM   = 9;
  localparam int IS_TX_TRIG = 10;
  localparam int IS_TX_OVR  = 12;

  typedef enum logic [2:0] {
    A_MASK_SET = 3'd0,
    A_MASK_CLR = 3'd1,
    A_MASK     = 3'd2,
    A_STICKY   = 3'd3,
    A_RX_TRIG  = 3'd4,
    A_TX_TRIG  = 3'd5,
    A_LIVE     = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/uart_live_status.sv
module uart_live_status import uart_irq_pkg::*; #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int CNT_W    = 7
) (
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_trig_i,
  input  logic [CNT_W-1:0]  tx_trig_i,
  output logic [LIVE_W-1:0] live_o
);
  localparam logic [CNT_W-1:0] RX_FULL_CNT = CNT_W'(RX_DEPTH);
  localparam logic [CNT_W-1:0] TX_FULL_CNT = CNT_W'(TX_DEPTH);

  always_comb begin
    live_o              = '0;
    live_o[LS_RX_TRIG]  = (rx_count_i >= rx_trig_i);
    live_o[LS_RX_EMPTY] = (rx_count_i == '0);
    live_o[LS_RX_FULL]  = (rx_count_i == RX_FULL_CNT);
    live_o[LS_TX_EMPTY] = (tx_count_i == '0);
    live_o[LS_TX_FULL]  = (tx_count_i == TX_FULL_CNT);
    live_o[LS_TX_TRIG]  = (tx_count_i >= tx_trig_i);
  end
endmodule

// File: rtl/uart_mask_reg.sv
module uart_mask_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (set_we_i) mask_o <= mask_o | wdata_i;
    else if (clr_we_i) mask_o <= mask_o & ~wdata_i;
  end
endmodule

// File: rtl/uart_sticky_reg.sv
module uart_sticky_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg import uart_irq_pkg::*; #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int TRIG_RST = 32,
  parameter int DATA_W   = 32,
  localparam int CNT_W   = $clog2((RX_DEPTH > TX_DEPTH ? RX_DEPTH : TX_DEPTH) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_timeout_i,
  input  logic              ev_modem_i,
  input  logic              ev_tx_ovr_i,
  output logic              irq_o
);
  logic [CNT_W-1:0]    rx_trig_q, tx_trig_q;
  logic [LIVE_W-1:0]   live_stat;
  logic [STICKY_W-1:0] sticky_q, sticky_set, sticky_clr, mask_q;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_trig_q <= CNT_W'(TRIG_RST);
      tx_trig_q <= CNT_W'(TRIG_RST);
    end else if (reg_we_i) begin
      if (reg_addr_i == A_RX_TRIG) rx_trig_q <= reg_wdata_i[CNT_W-1:0];
      if (reg_addr_i == A_TX_TRIG) tx_trig_q <= reg_wdata_i[CNT_W-1:0];
    end
  end

  uart_live_status #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .CNT_W(CNT_W)
  ) i_live (
    .rx_count_i(rx_count_i),
    .tx_count_i(tx_count_i),
    .rx_trig_i (rx_trig_q),
    .tx_trig_i (tx_trig_q),
    .live_o    (live_stat)
  );

  always_comb begin
    sticky_set             = '0;
    sticky_set[4:0]        = live_stat[4:0];
    sticky_set[IS_TX_TRIG] = live_stat[LS_TX_TRIG];
    sticky_set[IS_RX_OVR]  = ev_rx_ovr_i;
    sticky_set[IS_FRAME]   = ev_frame_i;
    sticky_set[IS_PARITY]  = ev_parity_i;
    sticky_set[IS_TIMEOUT] = ev_timeout_i;
    sticky_set[IS_MODEM]   = ev_modem_i;
    sticky_set[IS_TX_OVR]  = ev_tx_ovr_i;
  end

  assign sticky_clr = (reg_we_i && reg_addr_i == A_STICKY) ?
                      reg_wdata_i[STICKY_W-1:0] : '0;

  uart_sticky_reg #(.W(STICKY_W)) i_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_q)
  );

  uart_mask_reg #(.W(STICKY_W)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(reg_we_i && reg_addr_i == A_MASK_SET),
    .clr_we_i(reg_we_i && reg_addr_i == A_MASK_CLR),
    .wdata_i (reg_wdata_i[STICKY_W-1:0]),
    .mask_o  (mask_q)
  );

  assign irq_o = |(mask_q & sticky_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK:    reg_rdata_o = DATA_W'(mask_q);
      A_STICKY:  reg_rdata_o = DATA_W'(sticky_q);
      A_RX_TRIG: reg_rdata_o = DATA_W'(rx_trig_q);
      A_TX_TRIG: reg_rdata_o = DATA_W'(tx_trig_q);
      A_LIVE:    reg_rdata_o = DATA_W'(live_stat);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [13:0]       live_i,
  input logic [5:0]        ev_i,
  input logic [12:0]       sticky_i,
  input logic [12:0]       mask_i,
  input logic              irq_i
);
  logic [12:0] src;
  assign src = {ev_i[5], 1'b0, live_i[13], ev_i[4:0], live_i[4:0]};

  p_fold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_i[4:0] & $past(live_i[4:0])) == $past(live_i[4:0])));

  p_tx_trig_fold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i[13] |=> sticky_i[10]);

  p_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_i[9:5] & $past(ev_i[4:0])) == $past(ev_i[4:0])));

  p_bit11_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sticky_i[11]);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3) |=> ((sticky_i & $past(wdata_i[12:0] & ~src)) == 13'd0));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_i & $past(src)) == $past(src)));

  p_mask_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0) |=> ((mask_i & $past(wdata_i[12:0])) == $past(wdata_i[12:0])));

  p_mask_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1) |=> ((mask_i & $past(wdata_i[12:0])) == 13'd0));

  p_mask_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd2) |=> $stable(mask_i));

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (mask_i != 13'd0 && sticky_i != 13'd0));
endmodule

bind uart_irq_agg uart_irq_agg_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .live_i  (live_stat),
  .ev_i    ({ev_tx_ovr_i, ev_modem_i, ev_timeout_i, ev_parity_i, ev_frame_i, ev_rx_ovr_i}),
  .sticky_i(sticky_q),
  .mask_i  (mask_q),
  .irq_i   (irq_o)
);

// File: tb/test_uart_irq_agg.sv
module test_uart_irq_agg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  rx_cnt = 7'd5, tx_cnt = 7'd5;
  logic        e_rovr = 0, e_frm = 0, e_par = 0, e_to = 0, e_mdm = 0, e_tovr = 0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  uart_irq_agg i_uart_irq_agg (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_count_i(rx_cnt),
    .tx_count_i(tx_cnt), .ev_rx_ovr_i(e_rovr), .ev_frame_i(e_frm),
    .ev_parity_i(e_par), .ev_timeout_i(e_to), .ev_modem_i(e_mdm),
    .ev_tx_ovr_i(e_tovr), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  function automatic logic [31:0] exp_live(int rx, int tx, int rt, int tt);
    logic [31:0] v = '0;
    v[0] = rx >= rt; v[1] = rx == 0; v[2] = rx == 64;
    v[3] = tx == 0;  v[4] = tx == 64; v[13] = tx >= tt;
    return v;
  endfunction

  task automatic set_counts(int rx, int tx);
    @(negedge clk); rx_cnt = 7'(rx); tx_cnt = 7'(tx);
  endtask

  task automatic t_reset_r9;
    rd_chk("R9 mask", 3'd2, 0);
    rd_chk("R9 sticky", 3'd3, 0);
    rd_chk("R9 rx trig", 3'd4, 32);
    rd_chk("R9 tx trig", 3'd5, 32);
    check("R9 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_live_rx_r1;
    int vals[5] = '{0, 31, 32, 63, 64};
    foreach (vals[i]) begin
      set_counts(vals[i], 5);
      rd_chk("R1 live rx", 3'd6, exp_live(vals[i], 5, 32, 32));
    end
  endtask

  task automatic t_live_tx_r2;
    int vals[5] = '{0, 31, 32, 63, 64};
    foreach (vals[i]) begin
      set_counts(5, vals[i]);
      rd_chk("R2 live tx", 3'd6, exp_live(5, vals[i], 32, 32));
    end
    set_counts(5, 5);
  endtask

  task automatic t_fold_r3;
    wr(3'd3, 32'h1fff);
    rd_chk("R3 clean", 3'd3, 0);
    set_counts(64, 5);
    set_counts(5, 5);
    rd_chk("R3 rx full and trig", 3'd3, 32'h5);
    wr(3'd3, 32'h1fff);
    set_counts(5, 32);
    set_counts(5, 5);
    rd_chk("R3 tx trig to bit 10", 3'd3, 32'h400);
    wr(3'd3, 32'h1fff);
    set_counts(5, 0);
    set_counts(5, 5);
    rd_chk("R3 tx empty", 3'd3, 32'h8);
    wr(3'd3, 32'h1fff);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: e_rovr = 1; 1: e_frm = 1; 2: e_par = 1;
      3: e_to = 1;   4: e_mdm = 1; default: e_tovr = 1;
    endcase
    @(negedge clk);
    {e_rovr, e_frm, e_par, e_to, e_mdm, e_tovr} = '0;
  endtask

  task automatic t_events_r4;
    int pos[6] = '{5, 6, 7, 8, 9, 12};
    for (int k = 0; k < 6; k++) begin
      pulse(k);
      rd_chk("R4 event bit", 3'd3, 32'(1) << pos[k]);
      wr(3'd3, 32'h1fff);
    end
  endtask

  task automatic t_w1c_r5;
    set_counts(0, 5);
    pulse(0);
    pulse(1);
    rd_chk("R5 preset", 3'd3, 32'h62);
    wr(3'd3, 32'h20);
    rd_chk("R5 clear one", 3'd3, 32'h42);
    wr(3'd3, 32'h0);
    rd_chk("R5 zero write", 3'd3, 32'h42);
    wr(3'd3, 32'h2);
    rd_chk("R5 live re-set", 3'd3, 32'h42);
    set_counts(5, 5);
    wr(3'd3, 32'h42);
    rd_chk("R5 all clear", 3'd3, 0);
  endtask

  task automatic t_set_wins_r6;
    pulse(2);
    @(negedge clk); we = 1; addr = 3'd3; wdata = 32'h80; e_par = 1;
    @(negedge clk); we = 0; e_par = 0;
    rd_chk("R6 set wins", 3'd3, 32'h80);
    wr(3'd3, 32'h1fff);
  endtask

  task automatic t_mask_r7;
    wr(3'd0, 32'h5);
    wr(3'd0, 32'h100);
    rd_chk("R7 set", 3'd2, 32'h105);
    wr(3'd2, 32'h0);
    rd_chk("R7 direct ignored", 3'd2, 32'h105);
    wr(3'd1, 32'h4);
    rd_chk("R7 clear", 3'd2, 32'h101);
    wr(3'd1, 32'hffff);
    rd_chk("R7 clear all", 3'd2, 0);
  endtask

  task automatic t_irq_r8;
    wr(3'd0, 32'h20);
    check("R8 idle", {31'd0, irq}, 0);
    pulse(1);
    check("R8 unmasked bit", {31'd0, irq}, 0);
    pulse(0);
    check("R8 raised", {31'd0, irq}, 1);
    wr(3'd1, 32'h20);
    check("R8 masked off", {31'd0, irq}, 0);
    wr(3'd0, 32'h20);
    check("R8 re-enabled", {31'd0, irq}, 1);
    wr(3'd3, 32'h20);
    check("R8 cleared", {31'd0, irq}, 0);
    wr(3'd3, 32'h1fff);
  endtask

  task automatic t_trig_r10;
    wr(3'd4, 32'd10);
    rd_chk("R10 rx trig read", 3'd4, 10);
    set_counts(10, 5);
    rd_chk("R10 rx at trig", 3'd6, exp_live(10, 5, 10, 32));
    set_counts(9, 5);
    rd_chk("R10 rx below trig", 3'd6, exp_live(9, 5, 10, 32));
    wr(3'd5, 32'd3);
    rd_chk("R10 tx trig read", 3'd5, 3);
    rd_chk("R10 tx above trig", 3'd6, exp_live(9, 5, 10, 3));
    rd_chk("R10 unmapped", 3'd7, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    t_reset_r9;
    @(negedge clk); rst_ni = 1'b1;
    t_reset_r9;
    t_live_rx_r1;
    t_live_tx_r2;
    t_fold_r3;
    t_events_r4;
    t_w1c_r5;
    t_set_wins_r6;
    t_mask_r7;
    t_irq_r8;
    t_trig_r10;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule